// File: doc/BRIEF.md
# Match-Event PWM Timer

This block is a free-running up-counter shared by a bank of outputs. A set of compare registers holds counter values, and a set of events each watch one compare register. An event fires on a counter tick whose value equals the compare register it selects. Each output has one event bitmask that drives it high and another that drives it low. A separate limit bitmask names the events that send the counter back to zero. The limit therefore fixes one period for every output, and each output gets its own duty from its own compare event.

Software programs the block through a simple write strobe, address and data bus. Reads are combinational and return the current value of any register. A prescaler divides the count rate, and a halt bit freezes the counter. Each compare register has a shadow reload register. By default the compare register takes the shadow value at the limit event, so a new duty or period takes effect on a period boundary. When a set and a clear reach the same output in the same tick, a 2-bit code per output decides the result.

Top module: `sctpwm_top`

## Requirements
- R1: After reset the halt bit (control offset 0x004, bit 2) reads 1. Every other register reads 0, and all outputs are low.
- R2: A register read returns the last value written to the implemented fields. Config 0x000 keeps bit 0 (single counter) and bit 7 (reload off). Control 0x004 keeps bit 2 (halt) and bits 12:5 (prescale); bit 4 always reads 0. An event control word 0x304+8n keeps the compare select in bits 3:0 and the combine field in bits 13:12. Every other bit reads 0.
- R3: With prescale value P and halt clear, the counter advances once every P+1 clock cycles. Events are evaluated only on those tick cycles.
- R4: Event n is enabled only when bit 0 of its state word (0x300+8n) is 1 and its combine field holds 1. An enabled event fires on a tick where the selected compare register (0x100+4k) equals the counter. A disabled event has no effect on any output or on the counter.
- R5: Output n has a set mask at 0x500+8n and a clear mask at 0x504+8n. Bit e of a mask selects event e. If only set events fire, the output goes high in the cycle after the tick. If only clear events fire, it goes low in that cycle. Outputs never change on cycles without a tick.
- R6: When a fired event is in the limit mask (0x008), the counter's next value is 0. A limit compare value of N-1 therefore gives a period of N ticks.
- R7: The 2-bit field at bits 2n+1:2n of 0x058 decides output n when set and clear fire in the same tick: 0 keep, 1 high, 2 low, 3 invert.
- R8: While config bit 7 is 0, every compare register loads its reload register (0x200+4k) on a tick whose limit event fires. While bit 7 is 1, compare registers change only through direct writes. A direct write to a compare register takes priority over a reload in the same cycle.
- R9: While the halt bit is 1, the counter, the prescale phase and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 16 | Output levels |

## Verification
Two functions can coincide in one tick on the same output: a set event and a clear event. The bench provokes this by giving both masks the period event, or by placing a duty compare at the period's last count. It then judges each resolution code against a bench model and by counting high cycles over whole periods. The bench also collides a direct compare write with a period-boundary reload. It does this by halting the counter, writing the shadow register and reading back the live compare register before and after the boundary. Random register traffic then mixes all of these with prescale changes.

// File: rtl/sctpwm_pkg.sv
package sctpwm_pkg;
   typedef enum logic [1:0] {
      RES_KEEP = 2'd0,
      RES_HIGH = 2'd1,
      RES_LOW  = 2'd2,
      RES_FLIP = 2'd3
   } res_code_e;

   localparam int unsigned OFF_CFG    = 'h000;
   localparam int unsigned OFF_CTRL   = 'h004;
   localparam int unsigned OFF_LIMIT  = 'h008;
   localparam int unsigned OFF_RES    = 'h058;
   localparam int unsigned OFF_MATCH  = 'h100;
   localparam int unsigned OFF_RELOAD = 'h200;
   localparam int unsigned OFF_EVST   = 'h300;
   localparam int unsigned OFF_EVCTL  = 'h304;
   localparam int unsigned OFF_OSET   = 'h500;
   localparam int unsigned OFF_OCLR   = 'h504;

   localparam int unsigned CTRL_HALT_BIT = 2;
   localparam int unsigned CTRL_PRE_LSB  = 5;
   localparam int unsigned CFG_UNIFY_BIT = 0;
   localparam int unsigned CFG_NORL_BIT  = 7;
   localparam int unsigned COMB_LSB      = 12;
   localparam logic [1:0]  COMB_MATCH    = 2'd1;
endpackage

// File: rtl/sctpwm_counter.sv
module sctpwm_counter #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic [PRE_W-1:0] pre,
   input  logic             limit_hit,
   output logic             tick,
   output logic [CNT_W-1:0] cnt
);
   logic [PRE_W-1:0] phase_q;

   assign tick = !halt && (phase_q >= pre);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         cnt     <= '0;
      end else if (!halt) begin
         if (tick) begin
            phase_q <= '0;
            cnt     <= limit_hit ? '0 : cnt + 1'b1;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sctpwm_event.sv
module sctpwm_event #(
   parameter int N_CH  = 16,
   parameter int CNT_W = 32,
   parameter int SEL_W = 4
) (
   input  logic [N_CH-1:0][CNT_W-1:0] match_vec,
   input  logic [SEL_W-1:0]           sel,
   input  logic                       enable,
   input  logic                       tick,
   input  logic [CNT_W-1:0]           cnt,
   output logic                       fire
);
   logic in_range;

   assign in_range = (int'(sel) < N_CH);
   assign fire = tick && enable && in_range && (match_vec[sel] == cnt);
endmodule

// File: rtl/sctpwm_outcell.sv
module sctpwm_outcell
   import sctpwm_pkg::*;
#(
   parameter int N_CH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] fire,
   input  logic [N_CH-1:0] set_mask,
   input  logic [N_CH-1:0] clr_mask,
   input  logic [1:0]      code,
   output logic            set_hit,
   output logic            clr_hit,
   output logic            out_q
);
   logic out_d;

   assign set_hit = |(fire & set_mask);
   assign clr_hit = |(fire & clr_mask);

   always_comb begin
      out_d = out_q;
      if (set_hit && !clr_hit) begin
         out_d = 1'b1;
      end else if (clr_hit && !set_hit) begin
         out_d = 1'b0;
      end else if (set_hit && clr_hit) begin
         case (res_code_e'(code))
            RES_HIGH: out_d = 1'b1;
            RES_LOW:  out_d = 1'b0;
            RES_FLIP: out_d = ~out_q;
            default:  out_d = out_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
   end
endmodule

// File: rtl/sctpwm_top.sv
module sctpwm_top
   import sctpwm_pkg::*;
#(
   parameter int N_CH   = 16,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [N_CH-1:0]   pwm_out
);
   localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   if (N_CH < 2 || N_CH > 16) begin : g_bad_nch
      $error("sctpwm_top: N_CH must be 2..16");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cntw
      $error("sctpwm_top: CNT_W must be 2..32");
   end
   if (PRE_W < 1 || PRE_W > 8) begin : g_bad_prew
      $error("sctpwm_top: PRE_W must be 1..8");
   end
   if (ADDR_W < 11) begin : g_bad_addrw
      $error("sctpwm_top: ADDR_W too small for the register map");
   end

   logic                        cfg_unify_q, cfg_norl_q, halt_q;
   logic [PRE_W-1:0]            pre_q;
   logic [N_CH-1:0]             limit_q;
   logic [2*N_CH-1:0]           res_q;
   logic [N_CH-1:0][CNT_W-1:0]  match_q, reload_q;
   logic [N_CH-1:0]             st_en_q;
   logic [N_CH-1:0][SEL_W-1:0]  ev_sel_q;
   logic [N_CH-1:0][1:0]        ev_comb_q;
   logic [N_CH-1:0][N_CH-1:0]   set_mask_q, clr_mask_q;

   logic                        tick, limit_hit, reload_now;
   logic [CNT_W-1:0]            cnt_q;
   logic [N_CH-1:0]             fire, set_hit, clr_hit;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
      return a == ADDR_W'(off);
   endfunction

   assign limit_hit  = |(fire & limit_q);
   assign reload_now = tick && limit_hit && !cfg_norl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_unify_q <= 1'b0;
         cfg_norl_q  <= 1'b0;
         halt_q      <= 1'b1;
         pre_q       <= '0;
         limit_q     <= '0;
         res_q       <= '0;
         match_q     <= '0;
         reload_q    <= '0;
         st_en_q     <= '0;
         ev_sel_q    <= '0;
         ev_comb_q   <= '0;
         set_mask_q  <= '0;
         clr_mask_q  <= '0;
      end else begin
         if (bus_wr && hit(bus_addr, OFF_CFG)) begin
            cfg_unify_q <= bus_wdata[CFG_UNIFY_BIT];
            cfg_norl_q  <= bus_wdata[CFG_NORL_BIT];
         end
         if (bus_wr && hit(bus_addr, OFF_CTRL)) begin
            halt_q <= bus_wdata[CTRL_HALT_BIT];
            pre_q  <= bus_wdata[CTRL_PRE_LSB +: PRE_W];
         end
         if (bus_wr && hit(bus_addr, OFF_LIMIT)) limit_q <= bus_wdata[N_CH-1:0];
         if (bus_wr && hit(bus_addr, OFF_RES))   res_q   <= bus_wdata[2*N_CH-1:0];
         for (int i = 0; i < N_CH; i++) begin
            if (bus_wr && hit(bus_addr, OFF_MATCH + 4*i))
               match_q[i] <= bus_wdata[CNT_W-1:0];
            else if (reload_now)
               match_q[i] <= reload_q[i];
            if (bus_wr && hit(bus_addr, OFF_RELOAD + 4*i))
               reload_q[i] <= bus_wdata[CNT_W-1:0];
            if (bus_wr && hit(bus_addr, OFF_EVST + 8*i))
               st_en_q[i] <= bus_wdata[0];
            if (bus_wr && hit(bus_addr, OFF_EVCTL + 8*i)) begin
               ev_sel_q[i]  <= bus_wdata[SEL_W-1:0];
               ev_comb_q[i] <= bus_wdata[COMB_LSB +: 2];
            end
            if (bus_wr && hit(bus_addr, OFF_OSET + 8*i))
               set_mask_q[i] <= bus_wdata[N_CH-1:0];
            if (bus_wr && hit(bus_addr, OFF_OCLR + 8*i))
               clr_mask_q[i] <= bus_wdata[N_CH-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, OFF_CFG)) begin
         bus_rdata[CFG_UNIFY_BIT] = cfg_unify_q;
         bus_rdata[CFG_NORL_BIT]  = cfg_norl_q;
      end
      if (hit(bus_addr, OFF_CTRL)) begin
         bus_rdata[CTRL_HALT_BIT]              = halt_q;
         bus_rdata[CTRL_PRE_LSB +: PRE_W]      = pre_q;
      end
      if (hit(bus_addr, OFF_LIMIT)) bus_rdata[N_CH-1:0]   = limit_q;
      if (hit(bus_addr, OFF_RES))   bus_rdata[2*N_CH-1:0] = res_q;
      for (int i = 0; i < N_CH; i++) begin
         if (hit(bus_addr, OFF_MATCH + 4*i))  bus_rdata[CNT_W-1:0] = match_q[i];
         if (hit(bus_addr, OFF_RELOAD + 4*i)) bus_rdata[CNT_W-1:0] = reload_q[i];
         if (hit(bus_addr, OFF_EVST + 8*i))   bus_rdata[0] = st_en_q[i];
         if (hit(bus_addr, OFF_EVCTL + 8*i)) begin
            bus_rdata[SEL_W-1:0]     = ev_sel_q[i];
            bus_rdata[COMB_LSB +: 2] = ev_comb_q[i];
         end
         if (hit(bus_addr, OFF_OSET + 8*i)) bus_rdata[N_CH-1:0] = set_mask_q[i];
         if (hit(bus_addr, OFF_OCLR + 8*i)) bus_rdata[N_CH-1:0] = clr_mask_q[i];
      end
   end

   sctpwm_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt      (halt_q),
      .pre       (pre_q),
      .limit_hit (limit_hit),
      .tick      (tick),
      .cnt       (cnt_q)
   );

   for (genvar e = 0; e < N_CH; e++) begin : g_ev
      sctpwm_event #(.N_CH(N_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_ev (
         .match_vec (match_q),
         .sel       (ev_sel_q[e]),
         .enable    (st_en_q[e] && (ev_comb_q[e] == COMB_MATCH)),
         .tick      (tick),
         .cnt       (cnt_q),
         .fire      (fire[e])
      );
   end

   for (genvar o = 0; o < N_CH; o++) begin : g_out
      sctpwm_outcell #(.N_CH(N_CH)) u_out (
         .clk      (clk),
         .rst_n    (rst_n),
         .fire     (fire),
         .set_mask (set_mask_q[o]),
         .clr_mask (clr_mask_q[o]),
         .code     (res_q[2*o +: 2]),
         .set_hit  (set_hit[o]),
         .clr_hit  (clr_hit[o]),
         .out_q    (pwm_out[o])
      );
   end
endmodule

// File: rtl/sctpwm_chk.sv
module sctpwm_chk #(
   parameter int N_CH  = 16,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             limit_hit,
   input logic [CNT_W-1:0] cnt,
   input logic [N_CH-1:0]  pwm_out,
   input logic [N_CH-1:0]  set_hit,
   input logic [N_CH-1:0]  clr_hit
);
   // R3 / R9: no tick means the counter is frozen
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !limit_hit) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && limit_hit) |=> (cnt == '0));

   assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pwm_out));

   assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((pwm_out & $past(set_hit & ~clr_hit)) == $past(set_hit & ~clr_hit)));

   assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((pwm_out & $past(clr_hit & ~set_hit)) == '0));
endmodule

bind sctpwm_top sctpwm_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .limit_hit (limit_hit),
   .cnt       (cnt_q),
   .pwm_out   (pwm_out),
   .set_hit   (set_hit),
   .clr_hit   (clr_hit)
);

// File: tb/sctpwm_top_tb.sv
`timescale 1ns/1ps
module sctpwm_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pwm_out;

   int checks = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sctpwm_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   // ---------------- bench model built from the requirements ----------------
   logic [31:0] m_match [16];
   logic [31:0] m_reload[16];
   logic [15:0] m_setm  [16];
   logic [15:0] m_clrm  [16];
   logic [3:0]  m_sel   [16];
   logic [1:0]  m_comb  [16];
   logic [15:0] m_sten, m_limit, m_out, mf;
   logic [31:0] m_res, m_cnt;
   logic        m_halt, m_nr, mtk, mlim, ms, mc;
   logic [7:0]  m_pre, m_pc;
   logic [11:0] ma;

   function automatic logic resolve(input logic cur, input logic s, input logic c,
                                    input logic [1:0] code);
      if (s && !c) return 1'b1;
      if (c && !s) return 1'b0;
      if (!s && !c) return cur;
      case (code)
         2'd1: return 1'b1;
         2'd2: return 1'b0;
         2'd3: return ~cur;
         default: return cur;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            m_match[i] = '0; m_reload[i] = '0; m_setm[i] = '0;
            m_clrm[i] = '0; m_sel[i] = '0; m_comb[i] = '0;
         end
         m_sten = '0; m_limit = '0; m_out = '0; m_res = '0; m_cnt = '0;
         m_halt = 1'b1; m_nr = 1'b0; m_pre = '0; m_pc = '0;
      end else begin
         mtk = !m_halt && (m_pc >= m_pre);
         for (int e = 0; e < 16; e++)
            mf[e] = mtk && m_sten[e] && (m_comb[e] == 2'd1) && (m_match[m_sel[e]] == m_cnt);
         mlim = |(mf & m_limit);
         for (int o = 0; o < 16; o++) begin
            ms = |(mf & m_setm[o]);
            mc = |(mf & m_clrm[o]);
            m_out[o] = resolve(m_out[o], ms, mc, m_res[2*o +: 2]);
         end
         if (!m_halt) begin
            if (mtk) begin
               m_pc = '0;
               m_cnt = mlim ? 32'd0 : m_cnt + 32'd1;
            end else m_pc = m_pc + 8'd1;
         end
         if (mtk && mlim && !m_nr)
            for (int i = 0; i < 16; i++) m_match[i] = m_reload[i];
         if (bus_wr) begin
            ma = bus_addr;
            if (ma == 12'h000) m_nr = bus_wdata[7];
            if (ma == 12'h004) begin m_halt = bus_wdata[2]; m_pre = bus_wdata[12:5]; end
            if (ma == 12'h008) m_limit = bus_wdata[15:0];
            if (ma == 12'h058) m_res = bus_wdata;
            if (ma[1:0] == 2'b00) begin
               if (ma >= 12'h100 && ma < 12'h140) m_match[ma[5:2]] = bus_wdata;
               if (ma >= 12'h200 && ma < 12'h240) m_reload[ma[5:2]] = bus_wdata;
               if (ma >= 12'h300 && ma < 12'h380) begin
                  if (ma[2]) begin m_sel[ma[6:3]] = bus_wdata[3:0]; m_comb[ma[6:3]] = bus_wdata[13:12]; end
                  else m_sten[ma[6:3]] = bus_wdata[0];
               end
               if (ma >= 12'h500 && ma < 12'h580) begin
                  if (ma[2]) m_clrm[ma[6:3]] = bus_wdata[15:0];
                  else       m_setm[ma[6:3]] = bus_wdata[15:0];
               end
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = 12'(a);
      #1;
      chk(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   task automatic run(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(pwm_out === m_out, tag, {16'h0, pwm_out}, {16'h0, m_out});
      end
   endtask

   task automatic ev_cfg(input int e, input int sel, input int comb, input bit en);
      wr('h300 + 8*e, {31'h0, en});
      wr('h304 + 8*e, 32'((comb << 12) | sel));
   endtask

   task automatic out_cfg(input int o, input logic [15:0] s, input logic [15:0] c);
      wr('h500 + 8*o, {16'h0, s});
      wr('h504 + 8*o, {16'h0, c});
   endtask

   task automatic wait_change(input int idx, output int cyc);
      logic v;
      v = pwm_out[idx];
      cyc = 0;
      while (pwm_out[idx] == v && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      #(200000 * 5.0);
      if (!finished) begin
         checks++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      int cyc, hi1, hi3, hi4;
      logic [15:0] snap;
      void'($urandom(32'h5C7A_11E5));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk('h004, 32'h4, "R1 ctrl halt after reset");
      rd_chk('h000, 32'h0, "R1 cfg");
      rd_chk('h008, 32'h0, "R1 limit");
      rd_chk('h058, 32'h0, "R1 resolve");
      rd_chk('h114, 32'h0, "R1 compare5");
      rd_chk('h21C, 32'h0, "R1 reload7");
      rd_chk('h31C, 32'h0, "R1 event ctrl3");
      rd_chk('h510, 32'h0, "R1 set mask2");
      chk(pwm_out === 16'h0, "R1 outputs low", {16'h0, pwm_out}, 32'h0);

      // R2 readback with unimplemented bits
      wr('h004, 32'hFFFF_FFFF); rd_chk('h004, 32'h1FE4, "R2 ctrl fields");
      wr('h000, 32'hFFFF_FFFF); rd_chk('h000, 32'h81, "R2 cfg fields");
      wr('h32C, 32'hFFFF_FFFF); rd_chk('h32C, 32'h300F, "R2 event ctrl fields");
      wr('h11C, 32'hDEAD_BEEF); rd_chk('h11C, 32'hDEAD_BEEF, "R2 compare7");
      wr('h000, 0); wr('h32C, 0); wr('h11C, 0); wr('h004, 32'h4);

      // directed period / duty / conflict setup, period 10
      wr('h100, 9); wr('h200, 9); ev_cfg(0, 0, 1, 1); wr('h008, 1);
      wr('h104, 3); wr('h204, 3);
      wr('h108, 6); wr('h208, 6);
      wr('h10C, 9); wr('h20C, 9);
      wr('h110, 9); wr('h210, 9);
      for (int o = 1; o <= 4; o++) begin
         ev_cfg(o, o, 1, 1);
         out_cfg(o, 16'h1, 16'(1 << o));
      end
      out_cfg(5, 16'h1, 16'h1);
      out_cfg(6, 16'h1, 16'h1);
      wr('h058, (1 << 2) | (1 << 4) | (1 << 6) | (2 << 8) | (3 << 10));
      wr('h004, 0);
      run(40, "R5 directed model");

      // R5 / R7 duty and conflict windows
      while (pwm_out[1] !== 1'b0) @(negedge clk);
      while (pwm_out[1] !== 1'b1) @(negedge clk);
      hi1 = 1; hi3 = int'(pwm_out[3]); hi4 = int'(pwm_out[4]);
      repeat (9) begin
         @(negedge clk);
         hi1 += int'(pwm_out[1]); hi3 += int'(pwm_out[3]); hi4 += int'(pwm_out[4]);
      end
      chk(hi1 == 4, "R5 duty compare3 high count", hi1, 4);
      chk(hi3 == 10, "R7 code1 keeps output high", hi3, 10);
      chk(hi4 == 0, "R7 code2 keeps output low", hi4, 0);
      chk(pwm_out[6] === 1'b0, "R7 code0 keeps level", {31'h0, pwm_out[6]}, 0);

      // R6 period via code3 toggle on output 5
      wait_change(5, cyc); wait_change(5, cyc);
      chk(cyc == 10, "R6 period of 10 ticks", cyc, 10);

      // R3 prescale 2 -> 30 clocks per period
      wr('h004, 2 << 5);
      wait_change(5, cyc); wait_change(5, cyc);
      chk(cyc == 30, "R3 prescale stretches period", cyc, 30);
      run(60, "R3 prescale model");

      // R9 halt
      wr('h004, (1 << 2) | (2 << 5));
      snap = pwm_out;
      run(25, "R9 halted model");
      chk(pwm_out === snap, "R9 outputs hold while halted", {16'h0, pwm_out}, {16'h0, snap});

      // R8 reload at boundary, and reload disabled
      wr('h204, 6);
      rd_chk('h104, 3, "R8 compare unchanged before boundary");
      wr('h004, 2 << 5);
      run(70, "R8 reload model");
      rd_chk('h104, 6, "R8 compare reloaded at limit");
      wr('h000, 32'h80); wr('h204, 2);
      run(70, "R8 reload off model");
      rd_chk('h104, 6, "R8 compare kept with reload off");
      wr('h000, 0);
      run(70, "R8 reload back on");
      rd_chk('h104, 2, "R8 compare reloaded again");

      // R4 disabled events
      ev_cfg(2, 2, 1, 0);
      run(70, "R4 state disabled model");
      hi1 = 0;
      repeat (30) begin @(negedge clk); hi1 += int'(pwm_out[2]); end
      chk(hi1 == 30, "R4 disabled clear event ignored", hi1, 30);
      ev_cfg(2, 2, 2, 1);
      run(70, "R4 combine2 model");
      chk(pwm_out[2] === 1'b1, "R4 combine2 disables event", {31'h0, pwm_out[2]}, 1);
      ev_cfg(2, 2, 1, 1);
      run(70, "R4 re-enabled model");

      // random traffic
      for (int it = 0; it < 60; it++) begin
         int nw = 1 + int'($urandom_range(3));
         for (int w = 0; w < nw; w++) begin
            int i = int'($urandom_range(15));
            logic [31:0] d = $urandom;
            case ($urandom_range(8))
               0: begin wr('h100 + 4*i, d % 12); rd_chk('h100 + 4*i, d % 12, "R2 random compare"); end
               1: wr('h200 + 4*i, d % 12);
               2: ev_cfg(i, int'($urandom_range(15)), ($urandom_range(3) == 0) ? 2 : 1, $urandom_range(4) != 0);
               3: out_cfg(i, d[15:0], d[31:16]);
               4: wr('h058, d);
               5: wr('h008, {16'h0, d[15:0] | 16'h1});
               6: wr('h004, {19'h0, 8'(d % 4), 5'(($urandom_range(9) == 0) ? 4 : 0)});
               7: wr('h000, {24'h0, d[0], 7'h0});
               default: wr('h100, d % 14);
            endcase
         end
         run(40, "R7 random model");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule